// File: doc/BRIEF.md
# Trace Buffer Fill Counter

This block keeps track of how much valid capture data sits in a trace buffer of 64 lines, each line 64 bits wide and filled in two 32-bit halves. Every half-line store advances a 7-bit count by one. Bit 0 of the count marks a line of which only the first half is valid, and the upper six bits give the number of complete lines. The count is visible to software as an 8-bit read-only view. The top bit of that view is reserved and always reads as zero. Software cannot write the count, and reading trace data from the buffer does not lower it.

When the half-line store that completes the 64th line arrives, the count rolls over to zero and a sticky full flag is raised. What happens next depends on the trigger alignment. With end or mid alignment the store keeps going, and the count then measures how far newer data has overwritten the oldest lines. With begin alignment the session ends: a one-cycle request asks the control register to drop its arm bit, and later stores are ignored until software arms the block again.

Writing one to the arm bit clears the count and the full flag. Only the power-on reset does the same. An ordinary system reset leaves the count and flag intact, so the amount of data captured before that reset can still be read after it.

Top module: `trace_fill_counter`

## Requirements
- R1: Each clock with `halfWrStb` high, `armWrPulse` low and the session not ended raises the 7-bit count `countView[6:0]` by exactly one. Bit 0 of the count means half a line is valid and bits 6:1 give the number of whole lines.
- R2: A store made while the count is 127 (binary 1111111) returns the count to 0 and sets `bufFull` on the same clock edge.
- R3: `bufFull` is sticky. Later roll-overs and system resets leave it set, and only an arm write or power-on reset clears it.
- R4: With `alignMode` 2'b00 (end) or 2'b01 (mid), stores keep advancing the count after a roll-over. The value 2'b11 behaves like end.
- R5: With `alignMode` 2'b10 (begin), the roll-over ends the session. `armClrReq` is high for exactly the one cycle after that clock edge, and stores are ignored until the next arm write.
- R6: A clock with `armWrPulse` high sets the count to 0, clears `bufFull` and reopens an ended session. A store strobe in the same clock is ignored.
- R7: `porRst` clears the count, `bufFull`, `armClrReq` and the ended-session state. `sysRst` leaves the count and `bufFull` unchanged and only forces `armClrReq` low.
- R8: Bit 7 of `countView` always reads as 0.
- R9: A clock with neither a store strobe nor an arm write leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst | input | 1 | Power-on reset, active high, asynchronous |
| sysRst | input | 1 | Ordinary system reset, active high, synchronous |
| halfWrStb | input | 1 | One 32-bit half-line stored into the buffer |
| armWrPulse | input | 1 | Software wrote one to the arm bit |
| alignMode | input | 2 | Trigger alignment: 00 end, 01 mid, 10 begin, 11 end |
| countView | output | 8 | Read-only count view, bit 7 reserved zero |
| bufFull | output | 1 | Sticky buffer-full flag |
| armClrReq | output | 1 | One-cycle request to clear the arm bit |

## Verification
The bench builds the block with its default parameters: 64 lines, a 7-bit count and an 8-bit view. At 128 half-line stores per roll-over, a full wrap in every alignment mode is cheap to reach. So are a second wrap with the flag already set and a begin-mode session end followed by re-arming. A system reset pulse between wraps, an arm write that collides with a store, and a power-on reset in the middle of the run show that the two resets keep the count and flag apart as required.

// File: rtl/trace_fill_pkg.sv
package trace_fill_pkg;

  typedef enum logic [1:0] {
    ALIGN_END   = 2'b00,
    ALIGN_MID   = 2'b01,
    ALIGN_BEGIN = 2'b10,
    ALIGN_RSVD  = 2'b11
  } alignMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;  // arm write: zero count and flag
    logic advance;   // accept one half-line store
    logic markFull;  // this advance rolls the count over
  } fillStrb_t;

endpackage

// File: rtl/trace_fill_ctrl.sv
module trace_fill_ctrl
  import trace_fill_pkg::*;
(
  input  logic       clk,
  input  logic       porRst,
  input  logic       sysRst,
  input  logic       halfWrStb,
  input  logic       armWrPulse,
  input  logic [1:0] alignMode,
  input  logic       atLastHalf,
  output fillStrb_t  strobes,
  output logic       armClrReq,
  output logic       sessionStopped
);

  logic acceptStore;
  logic isBegin;
  logic endSession;

  assign isBegin     = (alignMode == ALIGN_BEGIN);
  assign acceptStore = halfWrStb && !armWrPulse && !sessionStopped;
  assign endSession  = acceptStore && atLastHalf && isBegin;

  always_comb begin
    strobes          = '0;
    strobes.clearAll = armWrPulse;
    strobes.advance  = acceptStore;
    strobes.markFull = acceptStore && atLastHalf;
  end

  // session-ended state: survives system reset, cleared by arm or power-on
  always_ff @(posedge clk or posedge porRst) begin
    if (porRst)          sessionStopped <= 1'b0;
    else if (armWrPulse) sessionStopped <= 1'b0;
    else if (endSession) sessionStopped <= 1'b1;
  end

  // one-cycle request to drop the arm bit
  always_ff @(posedge clk or posedge porRst) begin
    if (porRst)      armClrReq <= 1'b0;
    else if (sysRst) armClrReq <= 1'b0;
    else             armClrReq <= endSession;
  end

endmodule

// File: rtl/trace_fill_dp.sv
module trace_fill_dp
  import trace_fill_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             porRst,
  input  fillStrb_t        strobes,
  output logic [CNT_W-1:0] countVal,
  output logic             fullFlag,
  output logic             atLastHalf
);

  localparam logic [CNT_W-1:0] LAST_HALF = {CNT_W{1'b1}};

  assign atLastHalf = (countVal == LAST_HALF);

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst)                countVal <= '0;
    else if (strobes.clearAll) countVal <= '0;
    else if (strobes.advance)  countVal <= countVal + CNT_W'(1);
  end

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst)                fullFlag <= 1'b0;
    else if (strobes.clearAll) fullFlag <= 1'b0;
    else if (strobes.markFull) fullFlag <= 1'b1;
  end

endmodule

// File: rtl/trace_fill_counter.sv
module trace_fill_counter
  import trace_fill_pkg::*;
#(
  parameter int LINES_LOG2 = 6,
  parameter int VIEW_W     = 8
) (
  input  logic              clk,
  input  logic              porRst,
  input  logic              sysRst,
  input  logic              halfWrStb,
  input  logic              armWrPulse,
  input  logic [1:0]        alignMode,
  output logic [VIEW_W-1:0] countView,
  output logic              bufFull,
  output logic              armClrReq
);

  localparam int CNT_W = LINES_LOG2 + 1;

  fillStrb_t        strobes;
  logic [CNT_W-1:0] countVal;
  logic             atLastHalf;
  logic             sessionStopped;

  trace_fill_ctrl u_ctrl (
    .clk            (clk),
    .porRst         (porRst),
    .sysRst         (sysRst),
    .halfWrStb      (halfWrStb),
    .armWrPulse     (armWrPulse),
    .alignMode      (alignMode),
    .atLastHalf     (atLastHalf),
    .strobes        (strobes),
    .armClrReq      (armClrReq),
    .sessionStopped (sessionStopped)
  );

  trace_fill_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .porRst     (porRst),
    .strobes    (strobes),
    .countVal   (countVal),
    .fullFlag   (bufFull),
    .atLastHalf (atLastHalf)
  );

  generate
    if (VIEW_W > CNT_W) begin : g_pad
      assign countView = {{(VIEW_W-CNT_W){1'b0}}, countVal};
    end else begin : g_trim
      assign countView = countVal[VIEW_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/trace_fill_checker.sv
module trace_fill_checker #(
  parameter int CNT_W  = 7,
  parameter int VIEW_W = 8
) (
  input logic              clk,
  input logic              porRst,
  input logic              sysRst,
  input logic              halfWrStb,
  input logic              armWrPulse,
  input logic [VIEW_W-1:0] countView,
  input logic              bufFull,
  input logic              armClrReq,
  input logic              sessionStopped
);

  logic [CNT_W-1:0] cnt;
  assign cnt = countView[CNT_W-1:0];

  // R1: accepted store steps by one below the roll-over point
  p_step_r1: assert property (@(posedge clk) disable iff (porRst)
    halfWrStb && !armWrPulse && !sessionStopped && (cnt != {CNT_W{1'b1}})
    |=> countView[CNT_W-1:0] == $past(cnt) + CNT_W'(1));

  // R2: roll-over store lands on zero with the flag set
  p_wrap_full_r2: assert property (@(posedge clk) disable iff (porRst)
    halfWrStb && !armWrPulse && !sessionStopped && (cnt == {CNT_W{1'b1}})
    |=> (countView == '0) && bufFull);

  // R3: flag stays set unless armed again
  p_full_sticky_r3: assert property (@(posedge clk) disable iff (porRst)
    bufFull && !armWrPulse |=> bufFull);

  // R5: request lasts exactly one cycle and comes with a wrapped count
  p_clr_single_r5: assert property (@(posedge clk) disable iff (porRst)
    armClrReq |=> !armClrReq);
  p_clr_state_r5: assert property (@(posedge clk) disable iff (porRst)
    armClrReq |-> bufFull && sessionStopped);
  p_stopped_hold_r5: assert property (@(posedge clk) disable iff (porRst)
    sessionStopped && !armWrPulse |=> $stable(countView));

  // R6: arm write empties the buffer view
  p_arm_clear_r6: assert property (@(posedge clk) disable iff (porRst)
    armWrPulse |=> (countView == '0) && !bufFull && !sessionStopped);

  // R7: system reset leaves the count alone when no store arrives
  p_sys_keep_r7: assert property (@(posedge clk) disable iff (porRst)
    sysRst && !halfWrStb && !armWrPulse |=> $stable(countView) && !armClrReq);

  // R9: no activity holds the count
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (porRst)
    !halfWrStb && !armWrPulse |=> $stable(countView));

endmodule

bind trace_fill_counter trace_fill_checker #(.CNT_W(CNT_W), .VIEW_W(VIEW_W)) u_chk (
  .clk            (clk),
  .porRst         (porRst),
  .sysRst         (sysRst),
  .halfWrStb      (halfWrStb),
  .armWrPulse     (armWrPulse),
  .countView      (countView),
  .bufFull        (bufFull),
  .armClrReq      (armClrReq),
  .sessionStopped (sessionStopped)
);

// File: tb/test_trace_fill_counter.sv
`timescale 1ns/1ps
module test_trace_fill_counter;

  logic       clk = 1'b0;
  logic       porRst = 1'b0;
  logic       sysRst = 1'b0;
  logic       halfWrStb = 1'b0;
  logic       armWrPulse = 1'b0;
  logic [1:0] alignMode = 2'b00;
  logic [7:0] countView;
  logic       bufFull;
  logic       armClrReq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  int refCount = 0;
  bit refFull = 1'b0;
  bit refStopped = 1'b0;
  bit refClr = 1'b0;

  always #4 clk = ~clk;

  trace_fill_counter i_trace_fill_counter (
    .clk(clk), .porRst(porRst), .sysRst(sysRst), .halfWrStb(halfWrStb),
    .armWrPulse(armWrPulse), .alignMode(alignMode), .countView(countView),
    .bufFull(bufFull), .armClrReq(armClrReq)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string req);
    check(req, int'(countView[6:0]), refCount, "count");
    check(req, int'(bufFull), int'(refFull), "bufFull");
    check(req, int'(armClrReq), int'(refClr), "armClrReq");
    check("R8", int'(countView[7]), 0, "reserved bit");
  endtask

  task automatic cyc(input bit stb, input bit arm, input bit sys, input logic [1:0] mode,
                     input string req);
    @(negedge clk);
    halfWrStb = stb; armWrPulse = arm; sysRst = sys; alignMode = mode;
    @(posedge clk);
    refClr = 1'b0;
    if (arm) begin
      refCount = 0; refFull = 1'b0; refStopped = 1'b0;
    end else if (stb && !refStopped) begin
      if (refCount == 127) begin
        refCount = 0; refFull = 1'b1;
        if (mode == 2'b10) begin
          refStopped = 1'b1;
          refClr = !sys;
        end
      end else begin
        refCount++;
      end
    end
    #1;
    compareAll(req);
  endtask

  task automatic powerOn(input string req);
    @(negedge clk);
    porRst = 1'b1; halfWrStb = 1'b0; armWrPulse = 1'b0; sysRst = 1'b0;
    #2;
    refCount = 0; refFull = 1'b0; refStopped = 1'b0; refClr = 1'b0;
    compareAll(req);
    @(negedge clk);
    porRst = 1'b0;
  endtask

  task automatic fill(input int n, input logic [1:0] mode, input string req);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, mode, req);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    powerOn("R7");
    // R1: five halves, explicit value 2 lines + half
    fill(5, 2'b00, "R1");
    check("R1", int'(countView), 5, "five halves");
    // R9: idle holds
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, 2'b00, "R9");
    // R7: system reset keeps count
    cyc(1'b0, 1'b0, 1'b1, 2'b00, "R7");
    check("R7", int'(countView), 5, "count after sysRst");
    // R2: reach roll-over in end mode
    fill(122, 2'b00, "R1");
    check("R1", int'(countView), 127, "last half");
    cyc(1'b1, 1'b0, 1'b0, 2'b00, "R2");
    check("R2", int'(bufFull), 1, "full on wrap");
    // R4: keep counting, mid then reserved code
    fill(40, 2'b01, "R4");
    fill(20, 2'b11, "R4");
    cyc(1'b0, 1'b0, 1'b1, 2'b01, "R7");
    check("R3", int'(bufFull), 1, "full kept over sysRst");
    // R3: second wrap with flag set
    fill(70, 2'b01, "R3");
    check("R3", int'(bufFull), 1, "full after second wrap");
    // R6: arm with colliding strobe
    cyc(1'b1, 1'b1, 1'b0, 2'b00, "R6");
    check("R6", int'(countView), 0, "arm clears count");
    check("R6", int'(bufFull), 0, "arm clears full");
    // R5: begin alignment fill to end of session
    fill(127, 2'b10, "R5");
    cyc(1'b1, 1'b0, 1'b0, 2'b10, "R5");
    check("R5", int'(armClrReq), 1, "clear request raised");
    cyc(1'b1, 1'b0, 1'b0, 2'b10, "R5");
    check("R5", int'(armClrReq), 0, "clear request single cycle");
    fill(10, 2'b00, "R5");
    check("R5", int'(countView), 0, "stores ignored after end");
    // R6: re-arm reopens
    cyc(1'b0, 1'b1, 1'b0, 2'b10, "R6");
    fill(3, 2'b10, "R6");
    check("R6", int'(countView), 3, "counting after re-arm");
    // R7: power-on reset clears mid-session
    fill(130, 2'b00, "R2");
    powerOn("R7");
    check("R7", int'(bufFull), 0, "por clears full");
    fill(2, 2'b00, "R1");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule